// File: doc/BRIEF.md
# Floating-Point Conditional Branch Resolver

This block settles a branch that depends on a floating-point comparison. It takes a fetched 32-bit branch word, four 2-bit floating-point condition codes, and the current program counter (PC) and next program counter (NPC) of a delayed-branch pipeline. From these it works out whether the branch is taken, applies delay-slot annulment, and returns the PC/NPC pair for the following step.

Two instruction layouts are accepted. The basic layout always tests condition code 0 and carries a 22-bit word displacement. The predicated layout chooses one of the four condition codes and carries a 19-bit word displacement next to a prediction hint, which the block ignores. A strobe marks each valid word. The results are registered and stay unchanged until the next strobe.

Top module: `fbr_resolver`

## Requirements
- R1: While reset is active, and after it is released until the first strobe, `pc_o` is 0, `npc_o` is 4 and `taken_o` is 0.
- R2: The outputs change only on the clock edge that samples `valid_i` high, and they show the result for that edge's inputs. When `valid_i` is low the outputs hold, whatever the other inputs are doing.
- R3: The condition number is `insn_i[28:25]`. Each condition-code value means: 0 equal, 1 less, 2 greater, 3 unordered. The conditions, numbered 0 to 15, are: never, not-equal, less-or-greater, unordered-or-less, less, unordered-or-greater, greater, unordered, always, equal, unordered-or-equal, greater-or-equal, not-less, less-or-equal, not-greater, ordered.
- R4: A word uses the predicated layout when `insn_i[24:22]` equals 3'b101. In that layout, `insn_i[21:20]` = k selects condition code k, taken from `fcc_i[2k+1:2k]`. In every other case, condition code 0 (`fcc_i[1:0]`) is tested.
- R5: The displacement field is `insn_i[21:0]` in the basic layout and `insn_i[18:0]` in the predicated layout. It is sign-extended, multiplied by 4 and added to `pc_i` to form the target. All address arithmetic wraps modulo 2^64.
- R6: For a taken branch, other than always-with-annul, `pc_o` becomes the old NPC and `npc_o` becomes the target.
- R7: For condition always with annul (`insn_i[29]`) set, `pc_o` becomes the target and `npc_o` becomes the target plus 4, so the delay slot is skipped.
- R8: For a branch that is not taken with annul set, `pc_o` becomes the old NPC plus 4 and `npc_o` becomes the old NPC plus 8.
- R9: For a branch that is not taken with annul clear, `pc_o` becomes the old NPC and `npc_o` becomes the old NPC plus 4.
- R10: In the predicated layout, the prediction hint `insn_i[19]` has no effect on any output.
- R11: `taken_o` is registered together with the PC pair and shows whether the condition held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Strobe marking a valid branch word |
| insn_i | input | 32 | Branch instruction word |
| fcc_i | input | 8 | Four 2-bit condition codes; code k sits at bits [2k+1:2k] |
| pc_i | input | 64 | Current PC |
| npc_i | input | 64 | Current next-PC |
| pc_o | output | 64 | Registered new PC |
| npc_o | output | 64 | Registered new next-PC |
| taken_o | output | 1 | Registered branch-taken flag |

## Verification
The condition decision and the annul flag act on the same word in the same cycle. Their combination picks one of four PC updates, and always-with-annul follows its own path. The bench provokes every pairing by sweeping all sixteen conditions against all four code values, with annul both clear and set, in both layouts. The predicated sweep also changes which code field is selected. Random words then add wrap-around displacements and back-to-back strobes. A behavioural model predicts the PC pair and the taken flag, and these are compared on every clock.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

   // Instruction field positions used to decode the branch word
   localparam int unsigned ANNUL_POS = 29;
   localparam int unsigned COND_LSB  = 25;
   localparam int unsigned FMT_LSB   = 22;
   localparam int unsigned CCSEL_LSB = 20;
   localparam int unsigned HINT_POS  = 19;
   localparam logic [2:0]  FMT_PRED  = 3'b101;

   // Floating-point condition-code values
   localparam logic [1:0] CC_EQ = 2'd0;
   localparam logic [1:0] CC_LT = 2'd1;
   localparam logic [1:0] CC_GT = 2'd2;
   localparam logic [1:0] CC_UN = 2'd3;

   typedef enum logic [3:0] {
      FC_NEVER = 4'd0,  FC_NE   = 4'd1,  FC_LG  = 4'd2,  FC_UL  = 4'd3,
      FC_LT    = 4'd4,  FC_UG   = 4'd5,  FC_GT  = 4'd6,  FC_UN  = 4'd7,
      FC_ALWAYS= 4'd8,  FC_EQ   = 4'd9,  FC_UE  = 4'd10, FC_GE  = 4'd11,
      FC_NLT   = 4'd12, FC_LE   = 4'd13, FC_NGT = 4'd14, FC_ORD = 4'd15
   } fcond_e;

   // Set of condition-code values for which a condition holds.
   // Bit i of the result stands for condition-code value i.
   function automatic logic [3:0] cond_accept_set(input fcond_e c);
      logic [3:0] s;
      logic [3:0] e, l, g, u;
      e = 4'b0001 << CC_EQ;
      l = 4'b0001 << CC_LT;
      g = 4'b0001 << CC_GT;
      u = 4'b0001 << CC_UN;
      unique case (c)
         FC_NEVER:  s = 4'b0000;
         FC_NE:     s = ~e;
         FC_LG:     s = l | g;
         FC_UL:     s = u | l;
         FC_LT:     s = l;
         FC_UG:     s = u | g;
         FC_GT:     s = g;
         FC_UN:     s = u;
         FC_ALWAYS: s = 4'b1111;
         FC_EQ:     s = e;
         FC_UE:     s = u | e;
         FC_GE:     s = g | e;
         FC_NLT:    s = ~l;
         FC_LE:     s = l | e;
         FC_NGT:    s = ~g;
         FC_ORD:    s = ~u;
         default:   s = 4'b0000;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fbr_field_decode.sv
module fbr_field_decode
   import fbr_pkg::*;
#(
   parameter int unsigned INSN_W      = 32,
   parameter int unsigned ADDR_W      = 64,
   parameter int unsigned DISP_LONG_W = 22,
   parameter int unsigned DISP_SHRT_W = 19,
   parameter bit          SUPPORT_PRED = 1'b1
) (
   input  logic [INSN_W-1:0] insn,
   output fcond_e            cond,
   output logic              annul,
   output logic              is_pred,
   output logic [1:0]        cc_sel,
   output logic [ADDR_W-1:0] disp
);

   localparam int unsigned EXT_LONG = ADDR_W - DISP_LONG_W - 2;
   localparam int unsigned EXT_SHRT = ADDR_W - DISP_SHRT_W - 2;

   logic [ADDR_W-1:0] disp_long;
   logic [ADDR_W-1:0] disp_shrt;
   logic              unused_bits;

   assign cond  = fcond_e'(insn[COND_LSB +: 4]);
   assign annul = insn[ANNUL_POS];

   // Word displacement, sign-extended and scaled to bytes
   assign disp_long = {{EXT_LONG{insn[DISP_LONG_W-1]}}, insn[DISP_LONG_W-1:0], 2'b00};
   assign disp_shrt = {{EXT_SHRT{insn[DISP_SHRT_W-1]}}, insn[DISP_SHRT_W-1:0], 2'b00};

   generate
      if (SUPPORT_PRED) begin : g_pred
         assign is_pred = (insn[FMT_LSB +: 3] == FMT_PRED);
         assign cc_sel  = is_pred ? insn[CCSEL_LSB +: 2] : 2'd0;
         assign disp    = is_pred ? disp_shrt : disp_long;
      end else begin : g_basic
         assign is_pred = 1'b0;
         assign cc_sel  = 2'd0;
         assign disp    = disp_long;
      end
   endgenerate

   // Opcode bits and the prediction hint play no part here
   assign unused_bits = ^{insn[INSN_W-1:ANNUL_POS+1], insn[HINT_POS], disp_shrt[1:0]};

endmodule

// File: rtl/fbr_cond_eval.sv
module fbr_cond_eval
   import fbr_pkg::*;
#(
   parameter int unsigned FCC_NUM = 4,
   parameter int unsigned FCC_W   = 2
) (
   input  logic [FCC_NUM*FCC_W-1:0] fcc,
   input  logic [1:0]               cc_sel,
   input  fcond_e                   cond,
   output logic                     hit
);

   logic [FCC_W-1:0] fcc_arr [FCC_NUM];
   logic [FCC_W-1:0] fcc_pick;
   logic [3:0]       accept;

   generate
      for (genvar k = 0; k < FCC_NUM; k++) begin : g_split
         assign fcc_arr[k] = fcc[k*FCC_W +: FCC_W];
      end
   endgenerate

   assign fcc_pick = fcc_arr[cc_sel];
   assign accept   = cond_accept_set(cond);
   assign hit      = accept[fcc_pick];

endmodule

// File: rtl/fbr_pc_next.sv
module fbr_pc_next
   import fbr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 64,
   parameter int unsigned INSN_BYTES = 4
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [ADDR_W-1:0] npc,
   input  logic [ADDR_W-1:0] disp,
   input  logic              hit,
   input  logic              annul,
   input  logic              is_always,
   output logic [ADDR_W-1:0] pc_nx,
   output logic [ADDR_W-1:0] npc_nx
);

   localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INSN_BYTES);
   localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INSN_BYTES);

   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] target_p1;
   logic [ADDR_W-1:0] npc_p1;
   logic [ADDR_W-1:0] npc_p2;

   assign target    = pc + disp;
   assign target_p1 = target + STEP1;
   assign npc_p1    = npc + STEP1;
   assign npc_p2    = npc + STEP2;

   always_comb begin
      if (hit && annul && is_always) begin
         pc_nx  = target;
         npc_nx = target_p1;
      end else if (hit) begin
         pc_nx  = npc;
         npc_nx = target;
      end else if (annul) begin
         pc_nx  = npc_p1;
         npc_nx = npc_p2;
      end else begin
         pc_nx  = npc;
         npc_nx = npc_p1;
      end
   end

endmodule

// File: rtl/fbr_resolver.sv
module fbr_resolver
   import fbr_pkg::*;
#(
   parameter int unsigned INSN_W       = 32,
   parameter int unsigned ADDR_W       = 64,
   parameter int unsigned FCC_NUM      = 4,
   parameter int unsigned FCC_W        = 2,
   parameter int unsigned DISP_LONG_W  = 22,
   parameter int unsigned DISP_SHRT_W  = 19,
   parameter int unsigned INSN_BYTES   = 4,
   parameter bit          SUPPORT_PRED = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     valid_i,
   input  logic [INSN_W-1:0]        insn_i,
   input  logic [FCC_NUM*FCC_W-1:0] fcc_i,
   input  logic [ADDR_W-1:0]        pc_i,
   input  logic [ADDR_W-1:0]        npc_i,
   output logic [ADDR_W-1:0]        pc_o,
   output logic [ADDR_W-1:0]        npc_o,
   output logic                     taken_o
);

   localparam logic [ADDR_W-1:0] RST_PC  = '0;
   localparam logic [ADDR_W-1:0] RST_NPC = ADDR_W'(INSN_BYTES);

   // Elaboration-time parameter checks
   generate
      if (INSN_W != 32) begin : g_bad_insn
         $error("fbr_resolver: INSN_W must be 32");
      end
      if (FCC_NUM != 4 || FCC_W != 2) begin : g_bad_fcc
         $error("fbr_resolver: four 2-bit condition codes expected");
      end
      if (DISP_LONG_W > FMT_LSB || DISP_SHRT_W > HINT_POS) begin : g_bad_disp
         $error("fbr_resolver: displacement overlaps other fields");
      end
      if (ADDR_W < DISP_LONG_W + 3) begin : g_bad_addr
         $error("fbr_resolver: ADDR_W too narrow for displacement");
      end
   endgenerate

   fcond_e            cond;
   logic              annul;
   logic              is_pred;
   logic [1:0]        cc_sel;
   logic [ADDR_W-1:0] disp;
   logic              hit;
   logic [ADDR_W-1:0] pc_nx;
   logic [ADDR_W-1:0] npc_nx;
   logic              unused_fmt;

   fbr_field_decode #(
      .INSN_W      (INSN_W),
      .ADDR_W      (ADDR_W),
      .DISP_LONG_W (DISP_LONG_W),
      .DISP_SHRT_W (DISP_SHRT_W),
      .SUPPORT_PRED(SUPPORT_PRED)
   ) i_decode (
      .insn   (insn_i),
      .cond   (cond),
      .annul  (annul),
      .is_pred(is_pred),
      .cc_sel (cc_sel),
      .disp   (disp)
   );

   fbr_cond_eval #(
      .FCC_NUM(FCC_NUM),
      .FCC_W  (FCC_W)
   ) i_cond (
      .fcc   (fcc_i),
      .cc_sel(cc_sel),
      .cond  (cond),
      .hit   (hit)
   );

   fbr_pc_next #(
      .ADDR_W    (ADDR_W),
      .INSN_BYTES(INSN_BYTES)
   ) i_pcnx (
      .pc       (pc_i),
      .npc      (npc_i),
      .disp     (disp),
      .hit      (hit),
      .annul    (annul),
      .is_always(cond == FC_ALWAYS),
      .pc_nx    (pc_nx),
      .npc_nx   (npc_nx)
   );

   assign unused_fmt = is_pred;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_o    <= RST_PC;
         npc_o   <= RST_NPC;
         taken_o <= 1'b0;
      end else if (valid_i) begin
         pc_o    <= pc_nx;
         npc_o   <= npc_nx;
         taken_o <= hit;
      end
   end

endmodule

// File: rtl/fbr_resolver_chk.sv
module fbr_resolver_chk #(
   parameter int unsigned INSN_W = 32,
   parameter int unsigned ADDR_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_i,
   input logic [INSN_W-1:0] insn_i,
   input logic [ADDR_W-1:0] pc_i,
   input logic [ADDR_W-1:0] npc_i,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] npc_o,
   input logic              taken_o
);

   localparam logic [ADDR_W-1:0] FOUR  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] EIGHT = ADDR_W'(8);

   logic       a_bit;
   logic [3:0] c_fld;
   assign a_bit = insn_i[29];
   assign c_fld = insn_i[28:25];

   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pc_o == '0 && npc_o == FOUR && !taken_o)); // R1

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(taken_o))); // R2

   AST_NEVER_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && c_fld == 4'd0) |=> !taken_o); // R3

   AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && c_fld == 4'd8) |=> taken_o); // R11

   AST_TAKEN_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !(c_fld == 4'd8 && a_bit)) |=> (!taken_o || pc_o == $past(npc_i))); // R6

   AST_ANNUL_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && c_fld == 4'd8 && a_bit) |=> (npc_o == pc_o + FOUR)); // R7

   AST_SKIP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && a_bit) |=> (taken_o || (pc_o == $past(npc_i) + FOUR && npc_o == $past(npc_i) + EIGHT))); // R8

   AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !a_bit) |=> (taken_o || (pc_o == $past(npc_i) && npc_o == $past(npc_i) + FOUR))); // R9

   logic unused_chk;
   assign unused_chk = ^pc_i;

endmodule

bind fbr_resolver fbr_resolver_chk #(
   .INSN_W(INSN_W),
   .ADDR_W(ADDR_W)
) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .valid_i(valid_i),
   .insn_i (insn_i),
   .pc_i   (pc_i),
   .npc_i  (npc_i),
   .pc_o   (pc_o),
   .npc_o  (npc_o),
   .taken_o(taken_o)
);

// File: tb/test_fbr_resolver.sv
`timescale 1ns/1ps
module test_fbr_resolver;

   localparam realtime CLK_PER = 20.0;
   localparam int      WD_CYC  = 200000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        valid_i;
   logic [31:0] insn_i;
   logic [7:0]  fcc_i;
   logic [63:0] pc_i, npc_i;
   logic [63:0] pc_o, npc_o;
   logic        taken_o;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 0;
   string cur_tag;
   logic [63:0] e_pc, e_npc;
   logic        e_tk;

   always #(CLK_PER/2) clk = ~clk;

   fbr_resolver i_fbr_resolver (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
      .fcc_i(fcc_i), .pc_i(pc_i), .npc_i(npc_i),
      .pc_o(pc_o), .npc_o(npc_o), .taken_o(taken_o)
   );

   function automatic logic [31:0] mk_basic(input bit a, input int c, input logic [21:0] d);
      return {2'b00, a, 4'(c), 3'b110, d};
   endfunction

   function automatic logic [31:0] mk_pred(input bit a, input int c, input int cc,
                                          input bit hint, input logic [18:0] d);
      return {2'b00, a, 4'(c), 3'b101, 2'(cc), hint, d};
   endfunction

   // Behavioural reference: condition decision and PC pair
   task automatic ref_model(input logic [31:0] w, input logic [7:0] f,
                            input logic [63:0] p, input logic [63:0] np,
                            output logic [63:0] rp, output logic [63:0] rnp,
                            output logic rt);
      bit pred, a, eq, lt, gt, un, t;
      int sel, c;
      logic [1:0]  code;
      longint      off;
      pred = (w[24:22] == 3'd5);
      sel  = pred ? int'(w[21:20]) : 0;
      code = f[sel*2 +: 2];
      eq = (code == 0); lt = (code == 1); gt = (code == 2); un = (code == 3);
      c = int'(w[28:25]);
      a = w[29];
      case (c)
         0: t = 0;              1: t = lt || gt || un;
         2: t = lt || gt;       3: t = un || lt;
         4: t = lt;             5: t = un || gt;
         6: t = gt;             7: t = un;
         8: t = 1;              9: t = eq;
         10: t = un || eq;      11: t = gt || eq;
         12: t = eq || gt || un; 13: t = lt || eq;
         14: t = eq || lt || un; default: t = eq || lt || gt;
      endcase
      if (pred) off = longint'($signed(w[18:0])) * 4;
      else      off = longint'($signed(w[21:0])) * 4;
      rt = t;
      if (t && a && c == 8) begin
         rp  = p + 64'(off);
         rnp = rp + 64'd4;
      end else if (t) begin
         rp  = np;
         rnp = p + 64'(off);
      end else if (a) begin
         rp  = np + 64'd4;
         rnp = np + 64'd8;
      end else begin
         rp  = np;
         rnp = np + 64'd4;
      end
   endtask

   task automatic compare();
      n_chk++;
      if (pc_o !== e_pc || npc_o !== e_npc || taken_o !== e_tk) begin
         n_bad++;
         $display("FAIL %s: pc=%h npc=%h taken=%b expected pc=%h npc=%h taken=%b",
                  cur_tag, pc_o, npc_o, taken_o, e_pc, e_npc, e_tk);
      end
   endtask

   // Check the previous cycle's result, then drive the next one
   task automatic step(input bit v, input logic [31:0] w, input logic [7:0] f,
                       input logic [63:0] p, input logic [63:0] np, input string tag);
      logic [63:0] rp, rnp;
      logic        rt;
      @(negedge clk);
      compare();
      valid_i = v; insn_i = w; fcc_i = f; pc_i = p; npc_i = np;
      if (v) begin
         ref_model(w, f, p, np, rp, rnp, rt);
         e_pc = rp; e_npc = rnp; e_tk = rt;
      end
      cur_tag = tag;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #(CLK_PER * WD_CYC);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; valid_i = 1'b0; insn_i = '0; fcc_i = '0; pc_i = '0; npc_i = '0;
      e_pc = 64'd0; e_npc = 64'd4; e_tk = 1'b0;
      cur_tag = "R1 reset";
      repeat (3) @(negedge clk);
      compare();
      rst_n = 1'b1;
      // R1: idle after reset keeps reset values
      step(0, mk_basic(1, 8, 22'h1), 8'hFF, 64'h100, 64'h104, "R1 post-reset");
      // R6 basic taken, R11 flag
      step(1, mk_basic(0, 9, 22'h10), 8'h00, 64'h1000, 64'h1004, "R6 R11 equal taken");
      // R2 hold while idle with changing inputs
      step(0, mk_basic(1, 0, 22'h3), 8'h55, 64'hDEAD, 64'hBEEF, "R2 hold");
      step(0, '1, 8'hAA, '1, '1, "R2 hold");
      // R7 always with annul, negative displacement wrapping below zero
      step(1, mk_basic(1, 8, 22'h3FFFFF), 8'h03, 64'h0, 64'h4, "R7 R5 wrap");
      // R8 never with annul
      step(1, mk_basic(1, 0, 22'h55), 8'h00, 64'h2000, 64'h2004, "R8 annul skip");
      // R9 not taken, no annul, NPC wrap
      step(1, mk_basic(0, 4, 22'h55), 8'h00, 64'h10, 64'hFFFF_FFFF_FFFF_FFFC, "R9 fall through");
      // R4 predicated selects fcc2 (less) vs fcc0 (equal)
      step(1, mk_pred(0, 4, 2, 0, 19'h20), 8'b00_01_00_00, 64'h3000, 64'h3004, "R4 cc2 select");
      step(1, mk_pred(0, 4, 0, 0, 19'h20), 8'b00_01_00_00, 64'h3000, 64'h3004, "R4 cc0 select");
      // R4 basic layout ignores bits 21:20 for selection
      step(1, mk_basic(0, 9, 22'h300000), 8'b01_01_01_00, 64'h4000, 64'h4004, "R4 basic uses cc0");
      // R5 19-bit negative displacement
      step(1, mk_pred(0, 8, 3, 0, 19'h40000), 8'h00, 64'h8000_0000, 64'h8000_0004, "R5 short disp");
      // R10 hint set vs clear gives same result
      step(1, mk_pred(1, 11, 1, 1, 19'h7), 8'b00_00_10_00, 64'h500, 64'h504, "R10 hint set");
      step(1, mk_pred(1, 11, 1, 0, 19'h7), 8'b00_00_10_00, 64'h500, 64'h504, "R10 hint clear");
      // R3 full sweep, both layouts, annul both ways
      for (int fm = 0; fm < 2; fm++)
         for (int c = 0; c < 16; c++)
            for (int v = 0; v < 4; v++)
               for (int a = 0; a < 2; a++) begin
                  logic [31:0] w;
                  logic [7:0]  f;
                  int          k;
                  k = (c + v) % 4;
                  f = 8'($urandom);
                  if (fm == 1) begin
                     f[k*2 +: 2] = 2'(v);
                     w = mk_pred(a[0], c, k, c[0], 19'(c * 37 + v));
                  end else begin
                     f[1:0] = 2'(v);
                     w = mk_basic(a[0], c, 22'(c * 91 - v * 7000));
                  end
                  step(1, w, f, 64'h7000 + 64'(c * 16), 64'h7004 + 64'(c * 16), "R3 R6 R7 R8 R9 sweep");
               end
      // Random mix with occasional idle cycles
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] w;
         w = $urandom;
         if (($urandom % 2) == 0) w[24:22] = 3'b101;
         step(($urandom % 5) != 0, w, 8'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
              "R2 R4 R5 R11 random");
      end
      step(0, '0, '0, '0, '0, "R2 flush");
      @(negedge clk);
      compare();
      finished = 1;
      summary();
      $finish;
   end

endmodule